// File: doc/BRIEF.md
# Disk-Port Access Trap Recorder

This block sits beside an eight-port disk-interface I/O window that is running in pass-through mode. It watches each host I/O cycle and decides whether the cycle falls inside the window. When trapping is enabled, every access that hits the window produces a one-cycle system-management interrupt pulse. The block also latches a small descriptor of the access, so that a management handler can later emulate or log it.

The descriptor is one status byte. It packs address bit 9, address bit 2 and a two-bit byte-lane code that depends on the access size. A second byte holds the data of a byte-wide write; every other trapped access clears it. Reads that hit the window return all ones across the lanes of the access size. This read fill does not depend on the trap enable. The window base and the address width are parameters.

Top module: `io_trap_recorder`

## Requirements
- R1: While reset is asserted and right after it is released, `smi_pulse` is 0 and `trap_status` and `trap_data` are 0x00.
- R2: With `trap_en` low, no access raises `smi_pulse` and neither register changes.
- R3: An access cycle with `io_rd` or `io_wr` high, inside the window and with `trap_en` high, is trapped. `smi_pulse` is high in exactly the clock cycle after each trapped access cycle, and low after any cycle that is not trapped. Back-to-back trapped accesses give back-to-back high cycles.
- R4: On a trap, `trap_status` bit 5 takes address bit 9, bit 4 takes address bit 2, and bits 7:6 and 3:2 are written as 0.
- R5: On a trap, `trap_status[1:0]` depends on `io_size` (00 byte, 01 word, 10 dword, 11 handled as dword). A byte access stores address bits 1:0. A word access stores {address bit 1, 1}. A dword access stores 2'b11.
- R6: A trapped byte write loads `io_wdata[7:0]` into `trap_data`. Every other trapped access (any read, any word or dword write) loads 0x00.
- R7: In a cycle with `io_rd` high, `io_wr` low and the address inside the window, `rd_data` shows 0x000000FF for byte, 0x0000FFFF for word and 0xFFFFFFFF for dword (and for size 11). In any other cycle it is 0.
- R8: `trap_status` and `trap_data` update on the same edge that raises `smi_pulse`, and hold their value until the next trapped access.
- R9: When `io_rd` and `io_wr` are both high in one cycle, the access is treated as a write.
- R10: An address is inside the window when its bits above bit 2 equal those of `WIN_BASE`. Accesses outside the window are neither trapped nor given read fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address of the current cycle |
| io_size | input | 2 | Access size: 00 byte, 01 word, 10 dword, 11 dword |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 32 | Write data; byte writes use bits 7:0 |
| trap_en | input | 1 | Trap enable control bit |
| rd_data | output | 32 | Fill value returned for reads inside the window |
| smi_pulse | output | 1 | One-cycle management interrupt per trapped access |
| trap_status | output | 8 | Latched access descriptor |
| trap_data | output | 8 | Latched byte-write data, otherwise 0x00 |

## Verification
The bench runs two copies of the block. One has its window below address bit 9 and one above it, so a status bit 5 that is tied off or taken from the wrong address bit gets caught. Three mistakes get special attention. Word accesses at odd lane offsets would expose a lane code that passed address bit 0 through instead of forcing 1. A word or dword write right after a byte write would expose data that was held instead of cleared. A cycle with both strobes high would expose a decoder that treats the access as a read. Disabled-trap writes and addresses one port beyond either window edge would expose a design that pulses or overwrites its registers when it should stay silent.

// File: rtl/io_trap_pkg.sv
`timescale 1ns/1ps
package io_trap_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_WIDE  = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic [7:0] status;
    logic [7:0] data;
  } trap_rec_t;

  // byte-lane code for the low two status bits
  function automatic logic [1:0] lane_code(acc_size_e sz, logic [1:0] lo);
    logic [1:0] code;
    case (sz)
      SZ_BYTE: code = lo;
      SZ_WORD: code = {lo[1], 1'b1};
      default: code = 2'b11;
    endcase
    return code;
  endfunction

  function automatic logic [7:0] pack_status(logic a9, logic a2, logic [1:0] code);
    return {2'b00, a9, a2, 2'b00, code};
  endfunction

  function automatic logic [31:0] read_fill(acc_size_e sz);
    logic [31:0] fill;
    case (sz)
      SZ_BYTE: fill = 32'h0000_00FF;
      SZ_WORD: fill = 32'h0000_FFFF;
      default: fill = 32'hFFFF_FFFF;
    endcase
    return fill;
  endfunction

endpackage

// File: rtl/io_trap_decode.sv
`timescale 1ns/1ps
module io_trap_decode
  import io_trap_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h1F0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              rd,
  input  logic              wr,
  input  logic [7:0]        wbyte,
  input  logic              enable,
  output logic              win_hit,
  output logic              trap_fire,
  output logic              read_cycle,
  output trap_rec_t         rec,
  output logic [31:0]       fill
);
  localparam int unsigned HI_W = ADDR_W - 3;
  localparam logic [HI_W-1:0] BASE_HI = WIN_BASE[ADDR_W-1:3];

  acc_size_e sz;
  logic      is_write;
  logic      any_strobe;

  always_comb begin
    sz         = acc_size_e'(size);
    win_hit    = (addr[ADDR_W-1:3] == BASE_HI);
    any_strobe = rd | wr;
    is_write   = wr;                        // write wins when both strobes are high
    read_cycle = rd & ~wr & win_hit;
    trap_fire  = any_strobe & win_hit & enable;
    rec.status = pack_status(addr[9], addr[2], lane_code(sz, addr[1:0]));
    rec.data   = (is_write && sz == SZ_BYTE) ? wbyte : 8'h00;
    fill       = read_cycle ? read_fill(sz) : 32'h0;
  end
endmodule

// File: rtl/io_trap_regs.sv
`timescale 1ns/1ps
module io_trap_regs
  import io_trap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fire,
  input  trap_rec_t rec_in,
  output logic      smi,
  output trap_rec_t rec_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smi   <= 1'b0;
      rec_q <= '0;
    end else begin
      smi <= fire;
      if (fire) rec_q <= rec_in;
    end
  end
endmodule

// File: rtl/io_trap_recorder.sv
`timescale 1ns/1ps
module io_trap_recorder
  import io_trap_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h1F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [1:0]        io_size,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [31:0]       io_wdata,
  input  logic              trap_en,
  output logic [31:0]       rd_data,
  output logic              smi_pulse,
  output logic [7:0]        trap_status,
  output logic [7:0]        trap_data
);
  logic      win_hit;
  logic      trap_fire;
  logic      read_cycle;
  trap_rec_t rec_next;
  trap_rec_t rec_q;

  io_trap_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_decode (
    .addr      (io_addr),
    .size      (io_size),
    .rd        (io_rd),
    .wr        (io_wr),
    .wbyte     (io_wdata[7:0]),
    .enable    (trap_en),
    .win_hit   (win_hit),
    .trap_fire (trap_fire),
    .read_cycle(read_cycle),
    .rec       (rec_next),
    .fill      (rd_data)
  );

  io_trap_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (trap_fire),
    .rec_in(rec_next),
    .smi   (smi_pulse),
    .rec_q (rec_q)
  );

  assign trap_status = rec_q.status;
  assign trap_data   = rec_q.data;
endmodule

// File: rtl/io_trap_checker.sv
`timescale 1ns/1ps
module io_trap_checker #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic [1:0]        io_size,
  input logic              io_rd,
  input logic              io_wr,
  input logic [31:0]       io_wdata,
  input logic              trap_en,
  input logic [31:0]       rd_data,
  input logic              smi_pulse,
  input logic [7:0]        trap_status,
  input logic [7:0]        trap_data,
  input logic              win_hit,
  input logic              trap_fire
);
  assert_smi_follows_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> smi_pulse);

  assert_no_spurious_smi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_fire |=> !smi_pulse);

  assert_disabled_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_en |=> !smi_pulse);

  assert_outside_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |=> ($stable(trap_status) && $stable(trap_data)));

  assert_zero_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_status[7:6] == 2'b00) && (trap_status[3:2] == 2'b00));

  assert_bit9_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fire |=> (trap_status[5] == $past(io_addr[9])));

  assert_dword_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_fire && io_size[1]) |=> (trap_status[1:0] == 2'b11));

  assert_nonbyte_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_fire && !(io_wr && io_size == 2'b00)) |=> (trap_data == 8'h00));

  assert_read_byte_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && win_hit && io_size == 2'b00) |-> (rd_data == 32'h0000_00FF));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_fire |=> ($stable(trap_status) && $stable(trap_data)));

  assert_both_strobes_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_fire && io_rd && io_wr && io_size == 2'b00) |=> (trap_data == $past(io_wdata[7:0])));
endmodule

bind io_trap_recorder io_trap_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_addr    (io_addr),
  .io_size    (io_size),
  .io_rd      (io_rd),
  .io_wr      (io_wr),
  .io_wdata   (io_wdata),
  .trap_en    (trap_en),
  .rd_data    (rd_data),
  .smi_pulse  (smi_pulse),
  .trap_status(trap_status),
  .trap_data  (trap_data),
  .win_hit    (win_hit),
  .trap_fire  (trap_fire)
);

// File: tb/test_io_trap_recorder.sv
`timescale 1ns/1ps
module test_io_trap_recorder;
  localparam logic [15:0] BASE_A = 16'h01F0;
  localparam logic [15:0] BASE_B = 16'h03F0;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [15:0] addr;
  logic [1:0]  size;
  logic        rd, wr, en;
  logic [31:0] wdata;
  logic [31:0] rd_a, rd_b;
  logic        smi_a, smi_b;
  logic [7:0]  st_a, st_b, dt_a, dt_b;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_st_a = 8'h00, m_dt_a = 8'h00, m_st_b = 8'h00, m_dt_b = 8'h00;

  io_trap_recorder #(.ADDR_W(16), .WIN_BASE(BASE_A)) i_io_trap_recorder (
    .clk(clk), .rst_n(rst_n), .io_addr(addr), .io_size(size), .io_rd(rd), .io_wr(wr),
    .io_wdata(wdata), .trap_en(en), .rd_data(rd_a), .smi_pulse(smi_a),
    .trap_status(st_a), .trap_data(dt_a));

  io_trap_recorder #(.ADDR_W(16), .WIN_BASE(BASE_B)) i_io_trap_recorder_hi (
    .clk(clk), .rst_n(rst_n), .io_addr(addr), .io_size(size), .io_rd(rd), .io_wr(wr),
    .io_wdata(wdata), .trap_en(en), .rd_data(rd_b), .smi_pulse(smi_b),
    .trap_status(st_b), .trap_data(dt_b));

  function automatic bit in_win(logic [15:0] a, logic [15:0] base);
    return (a >> 3) == (base >> 3);
  endfunction

  function automatic logic [7:0] exp_status(logic [15:0] a, logic [1:0] sz);
    int v;
    v = (a[9] ? 32 : 0) + (a[2] ? 16 : 0);
    if (sz == 2'd0)      v = v + (a % 4);
    else if (sz == 2'd1) v = v + ((a & 16'h2) | 16'h1);
    else                 v = v + 3;
    return v[7:0];
  endfunction

  function automatic logic [31:0] exp_fill(logic [1:0] sz);
    if (sz == 2'd0) return 32'h0000_00FF;
    if (sz == 2'd1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a negative edge; returns at the following negative edge
  task automatic access(logic [15:0] a, logic [1:0] sz, logic r, logic w,
                        logic [31:0] d, logic e, string req);
    bit f_a, f_b;
    addr = a; size = sz; rd = r; wr = w; wdata = d; en = e;
    #1;
    chk({req, " R7"}, "rd_data A",
        (r && !w && in_win(a, BASE_A)) ? exp_fill(sz) : 32'h0, rd_a);
    chk({req, " R7"}, "rd_data B",
        (r && !w && in_win(a, BASE_B)) ? exp_fill(sz) : 32'h0, rd_b);
    f_a = (r || w) && e && in_win(a, BASE_A);
    f_b = (r || w) && e && in_win(a, BASE_B);
    if (f_a) begin
      m_st_a = exp_status(a, sz);
      m_dt_a = (w && sz == 2'd0) ? d[7:0] : 8'h00;
    end
    if (f_b) begin
      m_st_b = exp_status(a, sz);
      m_dt_b = (w && sz == 2'd0) ? d[7:0] : 8'h00;
    end
    @(negedge clk);
    chk({req, " R3"}, "smi A", {31'b0, smi_a}, {31'b0, f_a});
    chk({req, " R3"}, "smi B", {31'b0, smi_b}, {31'b0, f_b});
    chk({req, " R4 R5 R8"}, "status A", {24'b0, st_a}, {24'b0, m_st_a});
    chk({req, " R4 R5 R8"}, "status B", {24'b0, st_b}, {24'b0, m_st_b});
    chk({req, " R6 R8"}, "data A", {24'b0, dt_a}, {24'b0, m_dt_a});
    chk({req, " R6 R8"}, "data B", {24'b0, dt_b}, {24'b0, m_dt_b});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5471));
    rst_n = 1'b0; addr = '0; size = '0; rd = 1'b0; wr = 1'b0; wdata = '0; en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "smi in reset", {31'b0, smi_a}, 32'h0);
    chk("R1", "status in reset", {24'b0, st_b}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "status after reset", {24'b0, st_a}, 32'h0);
    chk("R1", "data after reset", {24'b0, dt_b}, 32'h0);

    // R2: disabled write inside both windows leaves everything untouched
    access(16'h01F3, 2'd0, 1'b0, 1'b1, 32'h5A, 1'b0, "R2");
    access(16'h03F6, 2'd1, 1'b1, 1'b0, 32'h0, 1'b0, "R2");
    // R6: byte write captures, word write then clears
    access(16'h01F6, 2'd0, 1'b0, 1'b1, 32'hABCD_12C7, 1'b1, "R6");
    access(16'h01F5, 2'd1, 1'b0, 1'b1, 32'h0000_3344, 1'b1, "R6");
    access(16'h03F1, 2'd0, 1'b0, 1'b1, 32'h0000_0099, 1'b1, "R6");
    access(16'h03F4, 2'd2, 1'b0, 1'b1, 32'h1111_2222, 1'b1, "R6");
    // R5: odd word offset, reserved size, byte read at lane 3
    access(16'h01F1, 2'd1, 1'b1, 1'b0, 32'h0, 1'b1, "R5");
    access(16'h03F7, 2'd3, 1'b1, 1'b0, 32'h0, 1'b1, "R5");
    access(16'h03F7, 2'd0, 1'b1, 1'b0, 32'h0, 1'b1, "R5");
    // R9: both strobes act as a write
    access(16'h01F2, 2'd0, 1'b1, 1'b1, 32'h0000_00E4, 1'b1, "R9");
    // R10: one port past each window edge
    access(16'h01F8, 2'd0, 1'b0, 1'b1, 32'h77, 1'b1, "R10");
    access(16'h03EF, 2'd0, 1'b1, 1'b0, 32'h0, 1'b1, "R10");
    // R3: back-to-back trapped reads, then idle
    access(16'h01F0, 2'd2, 1'b1, 1'b0, 32'h0, 1'b1, "R3");
    access(16'h01F4, 2'd1, 1'b1, 1'b0, 32'h0, 1'b1, "R3");
    access(16'h01F4, 2'd1, 1'b0, 1'b0, 32'h0, 1'b1, "R8");

    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      int pick;
      int kind;
      pick = $urandom_range(0, 9);
      if (pick < 4)      a = BASE_A | 16'($urandom_range(0, 7));
      else if (pick < 8) a = BASE_B | 16'($urandom_range(0, 7));
      else               a = 16'($urandom);
      kind = $urandom_range(0, 3);
      access(a, 2'($urandom_range(0, 3)), kind[0], kind[1], $urandom,
             ($urandom_range(0, 9) < 8), "RAND R2 R10");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule